// File: doc/BRIEF.md
# Keyboard Matrix Column Drive and Row Sense

This block sits between a keyboard matrix and the firmware that scans it. Firmware writes an 8-bit column selector. It can drive one column low, drive every column low at once to check for any press, or release every column. Each column pin is either driven low or released. A released pin is modelled as its output enable held low, so the column outputs carry only an enable per column.

The eight row sense lines are brought into the clock domain through a two-flop synchroniser and are presented as an active-low byte. The block watches each synchronised row for a falling edge, which is the moment a key on the driven column is pressed. It latches that edge in a per-row sticky status bit, which firmware clears by writing ones. A per-row enable mask selects which status bits raise the combined interrupt.

Top module: `kbd_matrix_scan`

## Requirements
- R1: After reset every column is released (`col_oe` all zero), `row_status` and `row_ien` are 0x00, `irq` is low and `row_raw` is 0xFF.
- R2: When selector bits 6 and 5 are both 0 and bits 4..0 hold an index below NCOL, exactly that one column has its `col_oe` bit set. The change appears the cycle after the write.
- R3: When selector bits 6 and 5 are both 0 and the index in bits 4..0 is NCOL or higher, no column is driven.
- R4: When selector bit 5 is 1 and bit 6 is 0, every column is driven at once, whatever bits 4..0 hold.
- R5: When selector bit 6 is 1, no column is driven, whatever bit 5 and bits 4..0 hold. This is also the reset value of the selector (0x40). Bit 7 of the selector is ignored.
- R6: `row_raw` follows `row_n_in` two clock edges later, unchanged in polarity: a 0 bit means the key is pressed.
- R7: A 1-to-0 transition on a synchronised row sets that row's `row_status` bit one edge after `row_raw` shows it, which is three edges after the pin changes. A 0-to-1 transition sets nothing.
- R8: A status write clears exactly the `row_status` bits written as 1 and leaves the bits written as 0 unchanged.
- R9: If a falling edge on a row is detected in the same cycle as a status write that clears that row, the status bit ends up set.
- R10: `irq` is high exactly when some row has both its `row_status` bit and its `row_ien` bit set. An enable write replaces the whole mask, and a status bit that is masked still holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_we | input | 1 | Write strobe for the column selector |
| sel_wdata | input | 8 | Selector value: bit 6 all off, bit 5 all on, bits 4..0 column index |
| ien_we | input | 1 | Write strobe for the row interrupt enable mask |
| ien_wdata | input | 8 | New row enable mask |
| sts_we | input | 1 | Write strobe for clearing row status |
| sts_wdata | input | 8 | Bits set to 1 clear the matching status bits |
| row_n_in | input | NROW | Asynchronous row sense lines, low when pressed |
| col_oe | output | NCOL | Per-column drive enable; 1 means the column is driven low |
| row_raw | output | NROW | Synchronised row levels, active low |
| row_status | output | NROW | Sticky falling-edge status per row |
| row_ien | output | NROW | Current row interrupt enable mask |
| irq | output | 1 | Combined row interrupt |

## Verification
The hardest case to reach from the ports is the collision in which a row's falling edge is detected in the same cycle as a status write that clears that row. The edge only exists inside the block, two edges after the pin moves. The bench lowers a row on a falling clock edge and counts two rising edges. In the window that follows, while the synchroniser's last stage has just turned low and the history flop has not yet caught up, it raises the clear strobe for that row. It then checks that the status bit survives the write.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int SEL_W    = 8;
  localparam int IDX_W    = 5;
  localparam int ALL_BIT  = 5;
  localparam int OFF_BIT  = 6;
  localparam logic [SEL_W-1:0] SEL_RESET = 8'h40;

  typedef enum logic [1:0] {
    COL_NONE   = 2'd0,
    COL_SINGLE = 2'd1,
    COL_ALL    = 2'd2
  } col_mode_e;

  // Off flag outranks the all flag; both clear selects one column.
  function automatic col_mode_e sel_mode(input logic [SEL_W-1:0] sel);
    if (sel[OFF_BIT])      return COL_NONE;
    else if (sel[ALL_BIT]) return COL_ALL;
    else                   return COL_SINGLE;
  endfunction

  function automatic logic [IDX_W-1:0] sel_index(input logic [SEL_W-1:0] sel);
    return sel[IDX_W-1:0];
  endfunction

  // Next sticky status: new edges win over a simultaneous clear.
  function automatic logic [7:0] sts_next(input logic [7:0] cur,
                                          input logic [7:0] clr,
                                          input logic [7:0] fall);
    return (cur & ~clr) | fall;
  endfunction
endpackage

// File: rtl/kms_col_decode.sv
module kms_col_decode
  import kms_pkg::*;
#(
  parameter int NCOL = 18
) (
  input  logic [SEL_W-1:0] sel,
  output logic [NCOL-1:0]  col_oe
);
  col_mode_e        mode;
  logic [IDX_W-1:0] idx;

  assign mode = sel_mode(sel);
  assign idx  = sel_index(sel);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam logic [IDX_W-1:0] CIDX = IDX_W'(c);
    always_comb begin
      unique case (mode)
        COL_ALL:    col_oe[c] = 1'b1;
        COL_SINGLE: col_oe[c] = (idx == CIDX);
        default:    col_oe[c] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kms_row_sync.sv
module kms_row_sync #(
  parameter int NROW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] row_async_n,
  output logic [NROW-1:0] row_sync_n,
  output logic [NROW-1:0] row_fall
);
  for (genvar r = 0; r < NROW; r++) begin : g_row
    logic meta_q, sync_q, hist_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
        hist_q <= 1'b1;
      end else begin
        meta_q <= row_async_n[r];
        sync_q <= meta_q;
        hist_q <= sync_q;
      end
    end
    assign row_sync_n[r] = sync_q;
    assign row_fall[r]   = hist_q & ~sync_q;
  end
endmodule

// File: rtl/kms_row_status.sv
module kms_row_status
  import kms_pkg::*;
#(
  parameter int NROW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NROW-1:0] fall,
  input  logic            clr_we,
  input  logic [NROW-1:0] clr_data,
  input  logic [NROW-1:0] ien,
  output logic [NROW-1:0] status,
  output logic            irq
);
  logic [NROW-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= NROW'(sts_next(8'(status), 8'(clr_mask), 8'(fall)));
  end

  assign irq = |(status & ien);
endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
  import kms_pkg::*;
#(
  parameter int NCOL = 18,
  parameter int NROW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [7:0]       sel_wdata,
  input  logic             ien_we,
  input  logic [7:0]       ien_wdata,
  input  logic             sts_we,
  input  logic [7:0]       sts_wdata,
  input  logic [NROW-1:0]  row_n_in,
  output logic [NCOL-1:0]  col_oe,
  output logic [NROW-1:0]  row_raw,
  output logic [NROW-1:0]  row_status,
  output logic [NROW-1:0]  row_ien,
  output logic             irq
);
  logic [SEL_W-1:0] sel_q;
  logic [NROW-1:0]  row_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= SEL_RESET;
      row_ien <= '0;
    end else begin
      if (sel_we) sel_q   <= sel_wdata;
      if (ien_we) row_ien <= sel_ien(ien_wdata);
    end
  end

  function automatic logic [NROW-1:0] sel_ien(input logic [7:0] d);
    return d[NROW-1:0];
  endfunction

  kms_col_decode #(.NCOL(NCOL)) u_cols (
    .sel    (sel_q),
    .col_oe (col_oe)
  );

  kms_row_sync #(.NROW(NROW)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_async_n (row_n_in),
    .row_sync_n  (row_raw),
    .row_fall    (row_fall)
  );

  kms_row_status #(.NROW(NROW)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (row_fall),
    .clr_we   (sts_we),
    .clr_data (sts_wdata[NROW-1:0]),
    .ien      (row_ien),
    .status   (row_status),
    .irq      (irq)
  );
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int NCOL = 18,
  parameter int NROW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      sel_q,
  input logic [NCOL-1:0] col_oe,
  input logic [NROW-1:0] row_n_in,
  input logic [NROW-1:0] row_raw,
  input logic [NROW-1:0] row_fall,
  input logic [NROW-1:0] row_status,
  input logic [NROW-1:0] row_ien,
  input logic            sts_we,
  input logic [7:0]      sts_wdata,
  input logic            irq
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[6] |-> (col_oe == '0));

  // R4
  all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[6:5] == 2'b01) |-> (&col_oe));

  // R2
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q[6:5] == 2'b00) |-> ($countones(col_oe) <= 1));

  // R6
  sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (row_raw == $past(row_n_in, 2)));

  // R7
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_fall) |=> ((row_status & $past(row_fall)) == $past(row_fall)));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((row_status & $past(sts_wdata[NROW-1:0] & ~row_fall)) == '0));

  // R10
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_status & row_ien) == '0) |-> !irq);
endmodule

bind kbd_matrix_scan kms_checker #(.NCOL(NCOL), .NROW(NROW)) u_kms_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_q      (sel_q),
  .col_oe     (col_oe),
  .row_n_in   (row_n_in),
  .row_raw    (row_raw),
  .row_fall   (row_fall),
  .row_status (row_status),
  .row_ien    (row_ien),
  .sts_we     (sts_we),
  .sts_wdata  (sts_wdata),
  .irq        (irq)
);

// File: tb/kbd_matrix_scan_bench.sv
module kbd_matrix_scan_bench;
  localparam int NCOL = 18;
  localparam int NROW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 0, ien_we = 0, sts_we = 0;
  logic [7:0] sel_wdata = 0, ien_wdata = 0, sts_wdata = 0;
  logic [NROW-1:0] row_n_in = '1;
  logic [NCOL-1:0] col_oe;
  logic [NROW-1:0] row_raw, row_status, row_ien;
  logic irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  kbd_matrix_scan #(.NCOL(NCOL), .NROW(NROW)) u_kbd_matrix_scan (
    .clk, .rst_n, .sel_we, .sel_wdata, .ien_we, .ien_wdata,
    .sts_we, .sts_wdata, .row_n_in, .col_oe, .row_raw,
    .row_status, .row_ien, .irq);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected column mask, restated from the requirements.
  function automatic logic [NCOL-1:0] exp_cols(input logic [7:0] s);
    logic [NCOL-1:0] m = '0;
    if (s[6]) m = '0;
    else if (s[5]) m = '1;
    else if (int'(s[4:0]) < NCOL) m[s[4:0]] = 1'b1;
    return m;
  endfunction

  task automatic wr_sel(input logic [7:0] v);
    @(negedge clk); sel_we = 1; sel_wdata = v;
    @(negedge clk); sel_we = 0;
  endtask
  task automatic wr_ien(input logic [7:0] v);
    @(negedge clk); ien_we = 1; ien_wdata = v;
    @(negedge clk); ien_we = 0;
  endtask
  task automatic wr_sts(input logic [7:0] v);
    @(negedge clk); sts_we = 1; sts_wdata = v;
    @(negedge clk); sts_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 col_oe", 32'(col_oe), 0);
    chk("R1 status", 32'(row_status), 0);
    chk("R1 ien", 32'(row_ien), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 raw", 32'(row_raw), 32'hFF);
  endtask

  task automatic t_columns;
    for (int i = 0; i < NCOL; i++) begin
      wr_sel(8'(i));
      chk("R2 single", 32'(col_oe), 32'(exp_cols(8'(i))));
    end
    wr_sel(8'd18); chk("R3 index 18", 32'(col_oe), 0);
    wr_sel(8'd31); chk("R3 index 31", 32'(col_oe), 0);
    wr_sel(8'h23); chk("R4 all", 32'(col_oe), 32'h3FFFF);
    wr_sel(8'hA0); chk("R5 bit7 ignored", 32'(col_oe), 32'h3FFFF);
    wr_sel(8'h60); chk("R5 off beats all", 32'(col_oe), 0);
    wr_sel(8'h44); chk("R5 off with index", 32'(col_oe), 0);
    wr_sel(8'h85); chk("R5 bit7 ignored single", 32'(col_oe), 32'h20);
  endtask

  task automatic t_row_edge;
    @(negedge clk); row_n_in = 8'hF7;
    @(negedge clk); chk("R6 raw after 1", 32'(row_raw), 32'hFF);
    @(negedge clk); chk("R6 raw after 2", 32'(row_raw), 32'hF7);
    chk("R7 not yet", 32'(row_status), 0);
    @(negedge clk); chk("R7 fall sets", 32'(row_status), 32'h08);
    chk("R10 masked", 32'(irq), 0);
    wr_ien(8'h08); chk("R10 irq on", 32'(irq), 1);
    wr_ien(8'hF7); chk("R10 irq off", 32'(irq), 0);
    chk("R10 status kept", 32'(row_status), 32'h08);
    wr_ien(8'hFF);
    wr_sts(8'h00); chk("R8 zero write", 32'(row_status), 32'h08);
    wr_sts(8'h08); chk("R8 cleared", 32'(row_status), 0);
    chk("R10 irq after clr", 32'(irq), 0);
    row_n_in = 8'hFF;
    repeat (4) @(negedge clk);
    chk("R7 rise ignored", 32'(row_status), 0);
    chk("R6 released", 32'(row_raw), 32'hFF);
  endtask

  task automatic t_multi;
    @(negedge clk); row_n_in = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R7 multi", 32'(row_status), 32'hA5);
    wr_sts(8'h81); chk("R8 partial", 32'(row_status), 32'h24);
    wr_sts(8'hFF); chk("R8 all", 32'(row_status), 0);
    @(negedge clk); row_n_in = 8'hFF;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_collision;
    @(negedge clk); row_n_in = 8'hFE;
    @(negedge clk);
    @(negedge clk); sts_we = 1; sts_wdata = 8'h01;
    @(negedge clk); sts_we = 0;
    chk("R9 set wins", 32'(row_status), 32'h01);
    wr_sts(8'hFF);
    chk("R9 clear later", 32'(row_status), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_columns();
    t_row_edge();
    t_multi();
    t_collision();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #50000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule